// File: doc/BRIEF.md
# Divided Compare-Match Timer

This block is an up-counter whose rate is set by a programmable prescaler of the system clock. Software starts and stops it with a run bit and clears it with a one-shot clear command. Software also sets a limit value and a divider value, may load the count directly, and reads back the count and a pair of status flags.

Each time the counter advances, it compares the new count with the limit. When the two are equal, both status flags are set and stay set until the next clear command. In the cycle the primary flag rises, a single-cycle event pulse goes out to the interrupt logic. After a match the counter keeps counting and wraps to zero past its maximum value.

Register access is through a simple synchronous write port and an index. Read data follows the index combinationally.

Top module: `divmatch_timer`

## Requirements
- R1: After reset, the control, divider, count and status registers all read 0, the limit register reads all ones, and the event output is low.
- R2: The counter advances only while control bit 0 (run) is 1. While run is 0 the count holds its value.
- R3: While running, the count advances once every N clock cycles, where N is the divider register value and a value of 0 counts as 1. The prescaler phase restarts from zero whenever run is 0 or a clear command is written.
- R4: When an advance makes the count equal to the limit, status bit 0 and status bit 1 are both set. They stay set until a clear command.
- R5: Counting continues after a match, and the count wraps from all ones to 0.
- R6: Writing control with bit 1 set is a clear command. It sets the count to 0, clears both status bits and has priority over an advance in the same cycle. Control bit 1 always reads back as 0.
- R7: The event output is high for exactly one cycle, in the cycle in which status bit 0 rises.
- R8: Writes to the status register are ignored. A direct load of the count never sets the status bits, even when the loaded value equals the limit.
- R9: The register indexes are 0 control, 1 limit, 2 divider, 3 count (writable) and 4 status. Any other index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current index |
| match_evt_o | output | 1 | One-cycle pulse when a match sets the status |

## Verification
A wrong prescaler phase shows up as a count that is off by one advance after a run window of known length. This appears as soon as the count is read back once the timer is stopped. A flag set on the wrong advance, or one that is lost, shows up in the status register and in the number of event pulses counted during that window. Both are visible within two cycles of the offending edge. A clear that fails to win over an advance leaves a nonzero count or a set flag on the very next read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned RUN_BIT = 0;
  localparam int unsigned CLR_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    IDX_CTRL  = 3'd0,
    IDX_LIMIT = 3'd1,
    IDX_DIV   = 3'd2,
    IDX_COUNT = 3'd3,
    IDX_FLAGS = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      cnt_i,
  input  logic [1:0]        flags_i,
  output logic              run_o,
  output logic              clr_o,
  output logic              load_o,
  output logic [W-1:0]      limit_o,
  output logic [W-1:0]      div_o,
  output logic [W-1:0]      rdata_o
);
  logic         run_q, run_d;
  logic [W-1:0] limit_q, limit_d;
  logic [W-1:0] div_q, div_d;
  logic         wr_ctrl, wr_limit, wr_div;

  always_comb begin
    wr_ctrl  = we_i && (addr_i == IDX_CTRL);
    wr_limit = we_i && (addr_i == IDX_LIMIT);
    wr_div   = we_i && (addr_i == IDX_DIV);
    run_d    = wr_ctrl  ? wdata_i[RUN_BIT] : run_q;
    limit_d  = wr_limit ? wdata_i : limit_q;
    div_d    = wr_div   ? wdata_i : div_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      limit_q <= '1;
      div_q   <= '0;
    end else begin
      run_q   <= run_d;
      limit_q <= limit_d;
      div_q   <= div_d;
    end
  end

  assign run_o   = run_q;
  assign clr_o   = wr_ctrl && wdata_i[CLR_BIT];
  assign load_o  = we_i && (addr_i == IDX_COUNT);
  assign limit_o = limit_q;
  assign div_o   = div_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      IDX_CTRL:  rdata_o[RUN_BIT] = run_q;
      IDX_LIMIT: rdata_o = limit_q;
      IDX_DIV:   rdata_o = div_q;
      IDX_COUNT: rdata_o = cnt_i;
      IDX_FLAGS: rdata_o[1:0] = flags_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] phase_q, phase_d;
  logic [W-1:0] last_phase;
  logic         tick;

  always_comb begin
    last_phase = (div_i == '0) ? '0 : div_i - 1'b1;
    tick       = run_i && !clr_i && (phase_q >= last_phase);
    if (!run_i || clr_i || tick) phase_d = '0;
    else                         phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign tick_o = tick;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic [1:0]   flags_o,
  output logic         evt_o
);
  logic [W-1:0] cnt_q, cnt_d, cnt_inc;
  logic         flag_q, flag_d;
  logic         mirror_q, mirror_d;
  logic         evt_q, evt_d;
  logic         adv, hit;

  always_comb begin
    cnt_inc  = cnt_q + 1'b1;
    adv      = tick_i && !clr_i && !load_i;
    hit      = adv && (cnt_inc == limit_i);
    if (clr_i)       cnt_d = '0;
    else if (load_i) cnt_d = load_val_i;
    else if (adv)    cnt_d = cnt_inc;
    else             cnt_d = cnt_q;
    flag_d   = clr_i ? 1'b0 : (flag_q   | hit);
    mirror_d = clr_i ? 1'b0 : (mirror_q | hit);
    evt_d    = hit && !flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      flag_q   <= 1'b0;
      mirror_q <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      flag_q   <= flag_d;
      mirror_q <= mirror_d;
      evt_q    <= evt_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign flags_o = {mirror_q, flag_q};
  assign evt_o   = evt_q;
endmodule

// File: rtl/divmatch_timer.sv
module divmatch_timer
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              match_evt_o
);
  logic             run, clr, load, tick;
  logic [CNT_W-1:0] limit, div, cnt;
  logic [1:0]       flags;

  tmr_regfile #(.W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .cnt_i(cnt), .flags_i(flags), .run_o(run),
    .clr_o(clr), .load_o(load), .limit_o(limit), .div_o(div),
    .rdata_o(bus_rdata_o)
  );

  tmr_prescaler #(.W(CNT_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clr_i(clr),
    .div_i(div), .tick_o(tick)
  );

  tmr_core #(.W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .clr_i(clr),
    .load_i(load), .load_val_i(bus_wdata_i), .limit_i(limit),
    .cnt_o(cnt), .flags_o(flags), .evt_o(match_evt_o)
  );
endmodule

// File: rtl/divmatch_timer_chk.sv
module divmatch_timer_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         clr,
  input logic         load,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic [1:0]   flags,
  input logic         evt
);
  assert_evt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  assert_evt_with_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> flags[0]);
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !clr) |=> flags[0]);
  assert_flags_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] == flags[1]);
  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !load) |=> $stable(cnt));
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0) && (flags == 2'b00) && !evt);
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !load && (cnt == '1)) |=> (cnt == '0));
endmodule

bind divmatch_timer divmatch_timer_chk #(.W(tmr_pkg::CNT_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .run(run), .clr(clr), .load(load),
  .tick(tick), .cnt(cnt), .flags(flags), .evt(match_evt_o)
);

// File: tb/divmatch_timer_bench.sv
module divmatch_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        evt;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          evt_seen = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  divmatch_timer u_divmatch_timer (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .match_evt_o(evt)
  );

  always @(posedge clk) if (evt) evt_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] ticks(input int w, input logic [31:0] dv);
    int n;
    n = (dv == 0) ? 1 : int'(dv);
    return (w + 2) / n;
  endfunction

  function automatic logic hit_expected(input logic [31:0] c0, input logic [31:0] lim,
                                        input logic [31:0] t);
    logic [31:0] d;
    d = lim - c0;
    return (d != 0) && (d <= t);
  endfunction

  task automatic trial(input string req, input logic [31:0] dv, input logic [31:0] lim,
                       input logic [31:0] c0, input int w);
    logic [31:0] v, t;
    logic        h;
    int          base;
    wr(3'd0, 32'h2);
    wr(3'd2, dv);
    wr(3'd1, lim);
    wr(3'd3, c0);
    base = evt_seen;
    wr(3'd0, 32'h1);
    repeat (w) @(negedge clk);
    wr(3'd0, 32'h0);
    repeat (2) @(negedge clk);
    t = ticks(w, dv);
    h = hit_expected(c0, lim, t);
    rd(3'd3, v); chk({req, " count"}, v, c0 + t);
    rd(3'd4, v); chk({req, " status"}, v, h ? 32'h3 : 32'h0);
    chk({req, " R7 event count"}, evt_seen - base, h ? 1 : 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, keep;
    void'($urandom(32'd41));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, R9 unused index
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 limit", v, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R1 div", v, 0);
    rd(3'd3, v); chk("R1 count", v, 0);
    rd(3'd4, v); chk("R1 status", v, 0);
    chk("R1 event", {31'd0, evt}, 0);
    rd(3'd6, v); chk("R9 unused index", v, 0);

    // R6 clear bit reads 0; R2 run bit reads back
    wr(3'd0, 32'h3);
    rd(3'd0, v); chk("R6 ctrl readback", v, 32'h1);
    wr(3'd0, 32'h2);

    // R3 directed dividers, including 0 as divide-by-1
    trial("R3 div0", 0, 100, 0, 10);
    trial("R3 div1", 1, 100, 0, 7);
    trial("R3 div3", 3, 100, 0, 20);
    trial("R3 div7", 7, 100, 0, 33);

    // R4 match boundary: exactly reached, and one short
    trial("R4 exact", 2, 6, 0, 10);
    trial("R4 short", 2, 7, 0, 10);

    // R5 wrap through zero with limit 0
    trial("R5 wrap", 1, 0, 32'hFFFF_FFFE, 5);

    // R8 status write ignored after match, R2 hold while stopped
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R8 status write ignored", v, 32'h3);
    rd(3'd3, keep);
    repeat (10) @(negedge clk);
    rd(3'd3, v); chk("R2 stopped hold", v, keep);

    // R6 clear with flag set
    wr(3'd0, 32'h2);
    rd(3'd3, v); chk("R6 clear count", v, 0);
    rd(3'd4, v); chk("R6 clear status", v, 0);

    // R8 load equal to limit sets nothing
    wr(3'd1, 32'd9);
    wr(3'd3, 32'd9);
    rd(3'd4, v); chk("R8 load no status", v, 0);
    rd(3'd3, v); chk("R9 count load", v, 32'd9);

    // random trials
    for (int i = 0; i < 40; i++) begin
      logic [31:0] dv, lim, c0;
      int w;
      dv  = $urandom % 5;
      lim = $urandom % 15;
      c0  = ($urandom % 4 == 0) ? (32'hFFFF_FFF8 + ($urandom % 8)) : 32'd0;
      if (c0 != 0) lim = c0 + ($urandom % 12);
      w   = $urandom % 40;
      trial("R4 random", dv, lim, c0, w);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule